// File: doc/BRIEF.md
# Stereo Digital Attenuator with Zero-Input Mute

This block sits in the sample path of a stereo audio converter, between the serial-input deserializer and the interpolation filter. Each accepted sample pair (two 24-bit two's-complement words) is scaled by a per-channel volume code. The code follows a logarithmic law of half a decibel per step, and code zero silences the channel completely. A soft-mute control walks the volume down one step per sample until the channel is silent, and walks it back up at the same rate when mute is released. The block also provides an output-polarity inversion control and a converter-off override that forces both channels to midscale (zero).

A zero-input detector watches for a long run of silence on the input. It counts bit-clock strobes that arrive after an all-zero sample pair, and raises a flag once the count reaches the threshold. When enabled, the flag also forces the outputs to zero. After reset is released, a hold counter keeps the outputs at zero for a fixed number of system clocks before real data is passed through.

Top module: `dig_atten_zmute`

## Requirements
- R1: With volume code c (8 bits), the output is round_half_up(x · M[a mod 12] / 2^(16 + a div 12)), where a = 255 − c. The mantissa table is M = {65536, 61858, 58386, 55109, 52016, 49097, 46341, 43740, 41285, 38968, 36781, 34716}. Code 0xFF therefore passes the input unchanged, and code 0x00 gives an output of exactly zero.
- R2: When `common_att` is 1, the right channel uses `code_l` and ignores `code_r`. When `common_att` is 0, each channel uses its own code.
- R3: An internal mute level m starts at 255 after reset. On each accepted sample, m steps down by 1 (stopping at 0) while `soft_mute` is 1, and steps up by 1 (stopping at 255) while `soft_mute` is 0. The effective code of a channel is min(code, m), using the value of m before that sample's update.
- R4: When `invert` is 1, each attenuated result is negated. Negating −8388608 saturates to +8388607.
- R5: When `dac_off` is 1, both output words of that sample are zero, whatever the input.
- R6: An accepted sample with any nonzero bit in either channel clears the zero counter and lowers `zero_flag`. After an all-zero sample pair, each `bclk_tick` increments the counter, which saturates at ZTHRESH (default 65536). `zero_flag` is 1 exactly when the counter has reached ZTHRESH. Before the 65536th tick, the flag is 0.
- R7: When `zmute_en` is 1 and `zero_flag` is 1 at the moment a sample is accepted, that sample's outputs are zero. When `zmute_en` is 0, the sample passes normally, and the flag still reports the condition.
- R8: After `rst_n` rises, samples accepted on the first 1024 rising clock edges produce zero outputs. A sample accepted on the 1025th edge or later is processed normally.
- R9: While `rst_n` is 0, `out_valid`, `left_out`, `right_out` and `zero_flag` are all 0.
- R10: `out_valid` is high on the cycle after each cycle in which `smp_valid` is high, and low otherwise. The output words hold their value between samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Sample pair present this cycle |
| left_in | input | 24 | Left input sample, two's complement |
| right_in | input | 24 | Right input sample, two's complement |
| bclk_tick | input | 1 | One-cycle strobe per serial bit clock |
| code_l | input | 8 | Left volume code |
| code_r | input | 8 | Right volume code |
| common_att | input | 1 | Apply left code to both channels |
| soft_mute | input | 1 | Ramp volume to silence |
| invert | input | 1 | Negate output polarity |
| dac_off | input | 1 | Force both outputs to zero |
| zmute_en | input | 1 | Let zero flag force outputs to zero |
| out_valid | output | 1 | Output pair updated this cycle |
| left_out | output | 24 | Left output sample |
| right_out | output | 24 | Right output sample |
| zero_flag | output | 1 | Long zero-input run detected |

## Verification
The hardest situation to reach is an input sample that arrives while the zero flag is already high. Reaching it takes 65536 bit-clock strobes after a silent pair, and on an all-zero input the forced mute cannot be seen at all. The stimulus therefore sends a silent pair and streams strobes one cycle apart, checking the flag just before and at the threshold. It then presents a nonzero pair, which the mute must zero when enabled and pass when disabled. The other demanding case is the soft-mute ramp, which the stimulus drives through more than 255 back-to-back samples in each direction, so that both the end stops and the min(code, level) rule are exercised.

// File: rtl/dig_atten_zmute.sv
module dig_atten_zmute #(
  parameter int ZTHRESH = 65536,
  parameter int HOLD    = 1024
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               smp_valid,
  input  logic signed [23:0] left_in,
  input  logic signed [23:0] right_in,
  input  logic               bclk_tick,
  input  logic [7:0]         code_l,
  input  logic [7:0]         code_r,
  input  logic               common_att,
  input  logic               soft_mute,
  input  logic               invert,
  input  logic               dac_off,
  input  logic               zmute_en,
  output logic               out_valid,
  output logic signed [23:0] left_out,
  output logic signed [23:0] right_out,
  output logic               zero_flag
);
  localparam int DW   = 24;
  localparam int PW   = DW + 18;
  localparam int CMAX = 255;
  localparam int ZCW  = $clog2(ZTHRESH + 1);
  localparam int HCW  = $clog2(HOLD + 1);
  localparam logic signed [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};
  localparam logic signed [DW-1:0] MAXV = {1'b0, {(DW-1){1'b1}}};

  logic [7:0]     mlev;
  logic [ZCW-1:0] zcnt;
  logic           zrun;
  logic [HCW-1:0] hcnt;
  logic           ready;
  logic [7:0]     el, er;
  logic signed [DW-1:0] vl, vr;
  logic           force0, nz_in;

  function automatic logic [16:0] mant(input int r);
    case (r)
      0: mant = 17'd65536;  1: mant = 17'd61858;  2: mant = 17'd58386;
      3: mant = 17'd55109;  4: mant = 17'd52016;  5: mant = 17'd49097;
      6: mant = 17'd46341;  7: mant = 17'd43740;  8: mant = 17'd41285;
      9: mant = 17'd38968; 10: mant = 17'd36781; default: mant = 17'd34716;
    endcase
  endfunction

  function automatic logic signed [DW-1:0] scale(input logic signed [DW-1:0] x,
                                                 input logic [7:0] c);
    int a, q, r;
    logic signed [PW-1:0] p;
    if (c == 8'd0) return '0;
    a = CMAX - int'(c);
    q = a / 12;
    r = a % 12;
    p = PW'(x) * PW'($signed({1'b0, mant(r)}));
    p = p + (PW'(1) <<< (15 + q));
    p = p >>> (16 + q);
    return p[DW-1:0];
  endfunction

  function automatic logic signed [DW-1:0] polar(input logic signed [DW-1:0] v,
                                                 input logic inv);
    if (!inv) return v;
    return (v == MINV) ? MAXV : -v;
  endfunction

  assign ready  = (hcnt == HCW'(HOLD));
  assign nz_in  = (left_in != '0) || (right_in != '0);
  assign el     = (code_l < mlev) ? code_l : mlev;
  assign er     = ((common_att ? code_l : code_r) < mlev) ?
                  (common_att ? code_l : code_r) : mlev;
  assign vl     = polar(scale(left_in, el), invert);
  assign vr     = polar(scale(right_in, er), invert);
  assign force0 = !ready || dac_off || (zmute_en && zero_flag);
  assign zero_flag = (zcnt == ZCW'(ZTHRESH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0;
    end else if (!ready) begin
      hcnt <= hcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mlev <= 8'd255;
    end else if (smp_valid) begin
      if (soft_mute && mlev != 8'd0)        mlev <= mlev - 8'd1;
      else if (!soft_mute && mlev != 8'd255) mlev <= mlev + 8'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zcnt <= '0;
      zrun <= 1'b1;
    end else if (smp_valid && nz_in) begin
      zcnt <= '0;
      zrun <= 1'b0;
    end else begin
      if (smp_valid) zrun <= 1'b1;
      if (bclk_tick && zrun && !zero_flag) zcnt <= zcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      left_out  <= '0;
      right_out <= '0;
    end else begin
      out_valid <= smp_valid;
      if (smp_valid) begin
        left_out  <= force0 ? '0 : vl;
        right_out <= force0 ? '0 : vr;
      end
    end
  end

  p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> out_valid);
  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> (!out_valid && $stable(left_out) && $stable(right_out)));
  p_dacoff_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && dac_off) |=> (left_out == '0 && right_out == '0));
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !ready) |=> (left_out == '0 && right_out == '0));
  p_zmute_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && zmute_en && zero_flag) |=> (left_out == '0 && right_out == '0));
  p_zclear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && nz_in) |=> !zero_flag);
  p_zstable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!bclk_tick && !smp_valid) |=> $stable(zero_flag));
  p_mlev_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(mlev));
  p_ramp_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && soft_mute && mlev != 8'd0) |=> (mlev == $past(mlev) - 8'd1));
endmodule

// File: tb/tb_dig_atten_zmute.sv
module tb_dig_atten_zmute;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0;
  logic signed [23:0] left_in = '0, right_in = '0;
  logic bclk_tick = 1'b0;
  logic [7:0] code_l = 8'hFF, code_r = 8'hFF;
  logic common_att = 1'b0, soft_mute = 1'b0, invert = 1'b0;
  logic dac_off = 1'b0, zmute_en = 1'b0;
  logic out_valid, zero_flag;
  logic signed [23:0] left_out, right_out;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;
  longint ql[$], qr[$];
  string  qt[$];
  longint M[12] = '{65536, 61858, 58386, 55109, 52016, 49097,
                    46341, 43740, 41285, 38968, 36781, 34716};

  always #2.5 clk = ~clk;

  dig_atten_zmute dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .left_in(left_in),
    .right_in(right_in), .bclk_tick(bclk_tick), .code_l(code_l), .code_r(code_r),
    .common_att(common_att), .soft_mute(soft_mute), .invert(invert),
    .dac_off(dac_off), .zmute_en(zmute_en), .out_valid(out_valid),
    .left_out(left_out), .right_out(right_out), .zero_flag(zero_flag)
  );

  function automatic longint expv(longint x, int c, bit inv);
    longint v, num, den, qq;
    int a;
    if (c == 0) v = 0;
    else begin
      a = 255 - c;
      num = x * M[a % 12];
      den = longint'(1) << (16 + a / 12);
      num = num + den / 2;
      qq = num / den;
      if ((num % den != 0) && num < 0) qq = qq - 1;
      v = qq;
    end
    if (inv) v = (v == -8388608) ? 8388607 : -v;
    return v;
  endfunction

  function automatic int imin(int a, int b);
    return (a < b) ? a : b;
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic send(longint l, longint r, longint el, longint er, string tag);
    left_in  = 24'(l);
    right_in = 24'(r);
    smp_valid = 1'b1;
    ql.push_back(el);
    qr.push_back(er);
    qt.push_back(tag);
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(int n);
    bclk_tick = 1'b1;
    repeat (n) @(negedge clk);
    bclk_tick = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (ql.size() == 0) begin
        chk(1'b0, "R10 unexpected output", 1, 0);
      end else begin
        longint el, er;
        string t;
        el = ql.pop_front();
        er = qr.pop_front();
        t  = qt.pop_front();
        chk(longint'(left_out) == el, {t, " left"}, longint'(left_out), el);
        chk(longint'(right_out) == er, {t, " right"}, longint'(right_out), er);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog expired", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    int codes[6] = '{255, 254, 243, 231, 1, 0};
    idle(4);
    chk(out_valid == 1'b0, "R9 out_valid in reset", longint'(out_valid), 0);
    chk(left_out == '0 && right_out == '0, "R9 outputs in reset", longint'(left_out), 0);
    chk(zero_flag == 1'b0, "R9 zero_flag in reset", longint'(zero_flag), 0);
    rst_n = 1'b1;
    repeat (1023) @(posedge clk);
    @(negedge clk);
    send(1000, -1000, 0, 0, "R8 edge 1024 held");
    send(1000, -1000, 1000, -1000, "R8 edge 1025 passes");
    idle(3);
    chk(out_valid == 1'b0, "R10 idle out_valid", longint'(out_valid), 0);

    foreach (codes[i]) begin
      code_l = 8'(codes[i]);
      code_r = 8'(codes[i]);
      send(3000001, -2999999, expv(3000001, codes[i], 0), expv(-2999999, codes[i], 0), "R1 law");
      send(-8388608, 8388607, expv(-8388608, codes[i], 0), expv(8388607, codes[i], 0), "R1 extremes");
    end

    code_l = 8'hF3; code_r = 8'hFF; common_att = 1'b1;
    send(400000, 400000, expv(400000, 243, 0), expv(400000, 243, 0), "R2 common");
    common_att = 1'b0;
    send(400000, 400000, expv(400000, 243, 0), 400000, "R2 individual");

    code_l = 8'hFF; code_r = 8'hE7; invert = 1'b1;
    send(-8388608, 123, 8388607, expv(123, 231, 1), "R4 saturate");
    send(8388607, -5000, -8388607, expv(-5000, 231, 1), "R4 negate");
    invert = 1'b0;

    dac_off = 1'b1;
    send(777, -777, 0, 0, "R5 dac off");
    dac_off = 1'b0;
    idle(3);

    code_l = 8'hFF; code_r = 8'hF3; soft_mute = 1'b1;
    for (int k = 0; k < 260; k++) begin
      int m;
      m = (255 - k < 0) ? 0 : 255 - k;
      send(4000000, -4000000, expv(4000000, imin(255, m), 0),
           expv(-4000000, imin(243, m), 0), "R3 ramp down");
    end
    soft_mute = 1'b0;
    for (int j = 0; j < 260; j++) begin
      int m;
      m = imin(j, 255);
      send(4000000, -4000000, expv(4000000, imin(255, m), 0),
           expv(-4000000, imin(243, m), 0), "R3 ramp up");
    end
    idle(3);

    code_l = 8'hFF; code_r = 8'hFF; zmute_en = 1'b1;
    send(5, 0, 5, 0, "R6 clear");
    send(0, 0, 0, 0, "R6 silent pair");
    idle(2);
    ticks(65535);
    chk(zero_flag == 1'b0, "R6 flag before threshold", longint'(zero_flag), 0);
    ticks(1);
    chk(zero_flag == 1'b1, "R6 flag at threshold", longint'(zero_flag), 1);
    send(1234, -1234, 0, 0, "R7 zero mute enabled");
    idle(2);
    chk(zero_flag == 1'b0, "R6 nonzero clears flag", longint'(zero_flag), 0);

    zmute_en = 1'b0;
    send(0, 0, 0, 0, "R6 silent pair");
    idle(2);
    ticks(65536);
    chk(zero_flag == 1'b1, "R7 flag reports while disabled", longint'(zero_flag), 1);
    send(1234, -1234, 1234, -1234, "R7 zero mute disabled");
    idle(2);
    chk(zero_flag == 1'b0, "R6 flag cleared again", longint'(zero_flag), 0);
    idle(3);
    chk(ql.size() == 0, "R10 all samples produced", longint'(ql.size()), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule